// File: doc/BRIEF.md
# FIFO Replay Read-Pointer Controller

This block adds replay to the read side of a dual-clock FIFO. It keeps two read pointers. The live pointer moves with every word the consumer takes. The mark pointer freezes the position of a chosen word. A consumer sets a mark on the word now held in the FIFO output register. It reads onward, and can then jump back to the marked word as often as it likes. While the mark is held, writes keep landing. The write-side flag logic sees only the frozen mark, so new data cannot overwrite words that may still be replayed.

The read-side flag logic and the memory read address take the live pointer directly, in the read clock domain. The write side gets a pointer view carried across into the write clock domain as Gray code. This view equals the mark while replay mode is active and the live pointer otherwise. The memory array and the flag threshold programming are outside this block.

Top module: `rtx_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the live pointer, mark pointer and write-side view are all zero, replay mode is off, and the error and replay pulses are low.
- R2: The live pointer advances by one, modulo 2*DEPTH, on a read-clock edge that samples `rd_en` and `out_vld` both high. A read with `out_vld` low leaves it unchanged.
- R3: Outside replay mode, an edge that samples `rtx_req` and `out_vld` both high enters the mode. The mark pointer takes the live pointer value from before that edge, which is the location of the word in the output register. A read on the same edge still advances the live pointer and counts as one read past the mark.
- R4: In replay mode, an edge that samples `rtx_req` low leaves the mode. The mark pointer keeps its value after exit.
- R5: In replay mode with `rtx_req` high, a `mark_req` edge reloads the live pointer from the mark pointer and pulses `replay_o` high for one cycle. This needs at least two reads since entry or since the last reload. A read on that same edge is dropped. The read count then restarts, and reloads may repeat without limit.
- R6: `mark_req` sampled high does not change the live pointer in three cases: outside replay mode, on the exit edge, or in mode with fewer than two reads past the mark. In each case `rtx_err_o` pulses high for one cycle.
- R7: The mark pointer does not change for as long as replay mode lasts.
- R8: The write-side view approaches its target one step at a time, so the Gray-coded source changes in at most one bit per read cycle. The target is the mark pointer in replay mode and the live pointer otherwise. A change reaches the write domain no sooner than the second write-clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rd | input | 1 | Read clock |
| clk_wr | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| rtx_req | input | 1 | Replay mode request, level sampled on clk_rd |
| mark_req | input | 1 | Jump-to-mark strobe, sampled on clk_rd |
| rd_en | input | 1 | Read request from the consumer |
| out_vld | input | 1 | Output register holds a word (output-ready status) |
| rd_ptr_o | output | $clog2(DEPTH)+1 | Live read pointer for read-side flags and memory address |
| mark_ptr_o | output | $clog2(DEPTH)+1 | Mark (shadow) read pointer |
| rtx_mode_o | output | 1 | Replay mode active |
| replay_o | output | 1 | One-cycle pulse after a reload to the mark |
| rtx_err_o | output | 1 | One-cycle pulse after an illegal jump-to-mark request |
| wr_view_ptr_o | output | $clog2(DEPTH)+1 | Read pointer seen by write-side flags, in the clk_wr domain |

## Verification
The live pointer, mark pointer, mode bit and both pulses are registered once. Their effect is due at the first read-clock edge after the inputs are applied. The bench drives inputs at the falling edge and samples one time unit after the next rising edge, so each table row is compared in exactly that cycle. The write-side view passes through a stepping register and two write-clock stages. The bench confirms it is still unchanged just after the first write edge following a mode exit. It compares the settled value only after tens of read cycles, by which point any stepping distance is covered.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
  // Reads counted past the marked word; saturates at the legal-jump level.
  typedef enum logic [1:0] {
    GAP_NONE = 2'd0,
    GAP_ONE  = 2'd1,
    GAP_MET  = 2'd2
  } gap_e;
endpackage

// File: rtl/rtx_rst_sync.sv
module rtx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign srst_n = chain_q[1];
endmodule

// File: rtl/rtx_mark_fsm.sv
module rtx_mark_fsm
  import rtx_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rtx_req,
  input  logic          mark_req,
  input  logic          rd_en,
  input  logic          out_vld,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] mark_ptr,
  output logic          mode,
  output logic          err,
  output logic          replay,
  output logic [AW-1:0] wr_target
);
  logic [AW-1:0] ptr_q, ptr_n, mark_q, mark_n;
  logic          mode_q, mode_n, err_q, err_n, rep_q, rep_n;
  gap_e          gap_q, gap_n;
  logic          rd_fire;

  assign rd_fire = rd_en & out_vld;

  always_comb begin
    ptr_n  = ptr_q;
    mark_n = mark_q;
    mode_n = mode_q;
    gap_n  = gap_q;
    err_n  = 1'b0;
    rep_n  = 1'b0;
    if (rd_fire) ptr_n = ptr_q + AW'(1);
    if (!mode_q) begin
      if (rtx_req && out_vld) begin
        mode_n = 1'b1;
        mark_n = ptr_q;
        gap_n  = rd_fire ? GAP_ONE : GAP_NONE;
      end
      if (mark_req) err_n = 1'b1;
    end else if (!rtx_req) begin
      mode_n = 1'b0;
      if (mark_req) err_n = 1'b1;
    end else if (mark_req && gap_q == GAP_MET) begin
      ptr_n = mark_q;
      gap_n = GAP_NONE;
      rep_n = 1'b1;
    end else begin
      if (mark_req) err_n = 1'b1;
      if (rd_fire && gap_q != GAP_MET) gap_n = gap_e'(gap_q + 2'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mark_q <= '0;
      mode_q <= 1'b0;
      gap_q  <= GAP_NONE;
      err_q  <= 1'b0;
      rep_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_n;
      mark_q <= mark_n;
      mode_q <= mode_n;
      gap_q  <= gap_n;
      err_q  <= err_n;
      rep_q  <= rep_n;
    end
  end

  assign rd_ptr    = ptr_q;
  assign mark_ptr  = mark_q;
  assign mode      = mode_q;
  assign err       = err_q;
  assign replay    = rep_q;
  assign wr_target = mode_q ? mark_q : ptr_q;
endmodule

// File: rtl/rtx_step_src.sv
module rtx_step_src #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] src_gray
);
  logic [AW-1:0] src_q, src_n, gray_q, gray_n;

  always_comb begin
    src_n  = (src_q != target) ? src_q + AW'(1) : src_q;
    gray_n = src_n ^ (src_n >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      gray_q <= '0;
    end else begin
      src_q  <= src_n;
      gray_q <= gray_n;
    end
  end

  assign src_gray = gray_q;
endmodule

// File: rtl/rtx_gray_sync.sv
module rtx_gray_sync #(
  parameter int unsigned AW     = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] gray_in,
  output logic [AW-1:0] bin_out
);
  logic [AW-1:0] stg_q [STAGES];
  logic [AW-1:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= gray_in;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign last = stg_q[STAGES-1];
  assign bin_out[AW-1] = last[AW-1];

  genvar b;
  generate
    for (b = AW - 1; b > 0; b--) begin : g_g2b
      assign bin_out[b-1] = bin_out[b] ^ last[b-1];
    end
  endgenerate
endmodule

// File: rtl/rtx_ctrl.sv
module rtx_ctrl #(
  parameter int unsigned DEPTH       = 512,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW         = $clog2(DEPTH) + 1
) (
  input  logic          clk_rd,
  input  logic          clk_wr,
  input  logic          rst_n,
  input  logic          rtx_req,
  input  logic          mark_req,
  input  logic          rd_en,
  input  logic          out_vld,
  output logic [AW-1:0] rd_ptr_o,
  output logic [AW-1:0] mark_ptr_o,
  output logic          rtx_mode_o,
  output logic          replay_o,
  output logic          rtx_err_o,
  output logic [AW-1:0] wr_view_ptr_o
);
  logic          rd_rst_n, wr_rst_n;
  logic [AW-1:0] wr_target, src_gray;

  rtx_rst_sync u_rst_rd (.clk(clk_rd), .arst_n(rst_n), .srst_n(rd_rst_n));
  rtx_rst_sync u_rst_wr (.clk(clk_wr), .arst_n(rst_n), .srst_n(wr_rst_n));

  rtx_mark_fsm #(.AW(AW)) u_fsm (
    .clk(clk_rd), .rst_n(rd_rst_n),
    .rtx_req(rtx_req), .mark_req(mark_req), .rd_en(rd_en), .out_vld(out_vld),
    .rd_ptr(rd_ptr_o), .mark_ptr(mark_ptr_o), .mode(rtx_mode_o),
    .err(rtx_err_o), .replay(replay_o), .wr_target(wr_target)
  );

  rtx_step_src #(.AW(AW)) u_step (
    .clk(clk_rd), .rst_n(rd_rst_n), .target(wr_target), .src_gray(src_gray)
  );

  rtx_gray_sync #(.AW(AW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_wr), .rst_n(wr_rst_n), .gray_in(src_gray), .bin_out(wr_view_ptr_o)
  );
endmodule

// File: rtl/rtx_ctrl_chk.sv
module rtx_ctrl_chk #(
  parameter int unsigned AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rtx_req,
  input logic          mark_req,
  input logic          out_vld,
  input logic [AW-1:0] rd_ptr,
  input logic [AW-1:0] mark_ptr,
  input logic          mode,
  input logic          err,
  input logic          replay,
  input logic [AW-1:0] src_gray
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mark_req |=> (rd_ptr == $past(rd_ptr)) || (rd_ptr == $past(rd_ptr) + AW'(1)));

  p_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && rtx_req && out_vld) |=> (mode && mark_ptr == $past(rd_ptr)));

  p_leave_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !rtx_req) |=> !mode);

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    replay |-> (rd_ptr == mark_ptr));

  p_stray_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && mark_req) |=> (err && !replay));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && rtx_req) |=> $stable(mark_ptr));

  p_gray_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_gray ^ $past(src_gray)) <= 1);
endmodule

bind rtx_ctrl rtx_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk_rd), .rst_n(rd_rst_n), .rtx_req(rtx_req), .mark_req(mark_req),
  .out_vld(out_vld), .rd_ptr(rd_ptr_o), .mark_ptr(mark_ptr_o), .mode(rtx_mode_o),
  .err(rtx_err_o), .replay(replay_o), .src_gray(src_gray)
);

// File: tb/rtx_ctrl_test.sv
module rtx_ctrl_test;
  localparam int PERIOD = 10;
  localparam int WR_HALF = 7;
  localparam int AW = 10;
  localparam int NV = 23;
  // {rtx_req, mark_req, rd_en, out_vld, rd_ptr, mode, mark_ptr, err, replay}
  localparam logic [26:0] VEC [NV] = '{
    {4'b0011, 10'd1, 1'b0, 10'd0, 1'b0, 1'b0},
    {4'b0010, 10'd1, 1'b0, 10'd0, 1'b0, 1'b0},
    {4'b0101, 10'd1, 1'b0, 10'd0, 1'b1, 1'b0},
    {4'b1000, 10'd1, 1'b0, 10'd0, 1'b0, 1'b0},
    {4'b1001, 10'd1, 1'b1, 10'd1, 1'b0, 1'b0},
    {4'b1101, 10'd1, 1'b1, 10'd1, 1'b1, 1'b0},
    {4'b1011, 10'd2, 1'b1, 10'd1, 1'b0, 1'b0},
    {4'b1101, 10'd2, 1'b1, 10'd1, 1'b1, 1'b0},
    {4'b1011, 10'd3, 1'b1, 10'd1, 1'b0, 1'b0},
    {4'b1111, 10'd1, 1'b1, 10'd1, 1'b0, 1'b1},
    {4'b1011, 10'd2, 1'b1, 10'd1, 1'b0, 1'b0},
    {4'b1101, 10'd2, 1'b1, 10'd1, 1'b1, 1'b0},
    {4'b1011, 10'd3, 1'b1, 10'd1, 1'b0, 1'b0},
    {4'b1011, 10'd4, 1'b1, 10'd1, 1'b0, 1'b0},
    {4'b1101, 10'd1, 1'b1, 10'd1, 1'b0, 1'b1},
    {4'b1011, 10'd2, 1'b1, 10'd1, 1'b0, 1'b0},
    {4'b1011, 10'd3, 1'b1, 10'd1, 1'b0, 1'b0},
    {4'b0101, 10'd3, 1'b0, 10'd1, 1'b1, 1'b0},
    {4'b0011, 10'd4, 1'b0, 10'd1, 1'b0, 1'b0},
    {4'b1011, 10'd5, 1'b1, 10'd4, 1'b0, 1'b0},
    {4'b1011, 10'd6, 1'b1, 10'd4, 1'b0, 1'b0},
    {4'b1101, 10'd4, 1'b1, 10'd4, 1'b0, 1'b1},
    {4'b0001, 10'd4, 1'b0, 10'd4, 1'b0, 1'b0}
  };

  logic clk_rd = 1'b0, clk_wr = 1'b0, rst_n = 1'b0;
  logic rtx_req = 1'b0, mark_req = 1'b0, rd_en = 1'b0, out_vld = 1'b0;
  logic [AW-1:0] rd_ptr_o, mark_ptr_o, wr_view_ptr_o;
  logic rtx_mode_o, replay_o, rtx_err_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk_rd = ~clk_rd;
  always #(WR_HALF) clk_wr = ~clk_wr;

  rtx_ctrl #(.DEPTH(512), .SYNC_STAGES(2)) uut (
    .clk_rd(clk_rd), .clk_wr(clk_wr), .rst_n(rst_n), .rtx_req(rtx_req),
    .mark_req(mark_req), .rd_en(rd_en), .out_vld(out_vld), .rd_ptr_o(rd_ptr_o),
    .mark_ptr_o(mark_ptr_o), .rtx_mode_o(rtx_mode_o), .replay_o(replay_o),
    .rtx_err_o(rtx_err_o), .wr_view_ptr_o(wr_view_ptr_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic rq, input logic mk, input logic rd, input logic ov);
    @(negedge clk_rd);
    rtx_req = rq; mark_req = mk; rd_en = rd; out_vld = ov;
    @(posedge clk_rd);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk_rd);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #3 chk("R1 rd_ptr in reset", int'(rd_ptr_o), 0);
    chk("R1 mode in reset", int'(rtx_mode_o), 0);
    repeat (4) @(posedge clk_rd);
    @(negedge clk_rd) rst_n = 1'b1;
    repeat (4) @(posedge clk_rd);
    #1;
    chk("R1 rd_ptr after release", int'(rd_ptr_o), 0);
    chk("R1 mark_ptr after release", int'(mark_ptr_o), 0);
    chk("R1 wr view after release", int'(wr_view_ptr_o), 0);
    chk("R1 pulses after release", int'({rtx_err_o, replay_o}), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23]);
      chk($sformatf("R2/R5 rd_ptr row %0d", i), int'(rd_ptr_o), int'(VEC[i][22:13]));
      chk($sformatf("R3/R4 mode row %0d", i), int'(rtx_mode_o), int'(VEC[i][12]));
      chk($sformatf("R7 mark_ptr row %0d", i), int'(mark_ptr_o), int'(VEC[i][11:2]));
      chk($sformatf("R6 error row %0d", i), int'(rtx_err_o), int'(VEC[i][1]));
      chk($sformatf("R5 replay row %0d", i), int'(replay_o), int'(VEC[i][0]));
    end

    // R8: outside the mode the write view settles on the live pointer
    repeat (20) drive(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 view tracks live pointer", int'(wr_view_ptr_o), 4);

    // R8: in the mode the write view stays on the mark while reads continue
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    repeat (5) drive(1'b1, 1'b0, 1'b1, 1'b1);
    repeat (20) drive(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R2 live pointer after reads", int'(rd_ptr_o), 9);
    chk("R7 mark held", int'(mark_ptr_o), 4);
    chk("R8 view held on mark", int'(wr_view_ptr_o), 4);

    // R8: release after exit needs at least two write edges
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R4 exit", int'(rtx_mode_o), 0);
    @(posedge clk_wr);
    #1 chk("R8 not released at first write edge", int'(wr_view_ptr_o), 4);
    repeat (30) drive(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 view released to live pointer", int'(wr_view_ptr_o), 9);
    chk("R4 mark kept after exit", int'(mark_ptr_o), 4);

    // R1: reset in mid-run clears everything at once
    @(negedge clk_rd) rst_n = 1'b0;
    #1;
    chk("R1 rd_ptr on reset", int'(rd_ptr_o), 0);
    chk("R1 mark_ptr on reset", int'(mark_ptr_o), 0);
    chk("R1 wr view on reset", int'(wr_view_ptr_o), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule